// File: doc/BRIEF.md
# UART Modem-Control Loopback Unit

This block sits beside a UART's control register and reroutes the modem handshake outputs onto the modem status inputs when the loopback enable bit is set. It owns the five control bits it cares about: loopback enable, two user outputs, request-to-send and data-terminal-ready. From them it produces the four status flag bits (ring, carrier detect, clear-to-send, data-set-ready) and the four matching modem-status raw interrupt bits. Software uses it to run a self test. It sets loopback and toggles the handshake outputs. It then reads back the status flags and the interrupt bits without any cable attached.

With loopback on, the block also feeds each transmitted character straight into the receive path and drops characters from the external line. When the send-break bit turns on, it injects a break word. With loopback off, the status flags follow the external modem pins through a synchronizer. The handshake outputs drive the pins, and received line data passes through.

Top module: `uart_mdm_loop`

## Requirements
- R1: After reset, `stat_ms`, `ms_raw`, `pin_mc`, `lb_active` and `rx_valid` are all zero.
- R2: One cycle after a control write with `cr_lbe`=1, `stat_ms` holds the crossed map. Bit 0 (ring) takes OUT2, bit 1 (carrier) takes OUT1, bit 2 (clear-to-send) takes RTS, and bit 3 (data-set-ready) takes DTR.
- R3: The map is applied on every control write with `cr_lbe`=1. This includes a write whose only change is setting the enable bit.
- R4: Each such write first clears all four raw bits and then sets each bit whose looped status bit is high. A rebuild in the same cycle overrides `ms_clr`. Otherwise a 1 in `ms_clr` bit n clears `ms_raw` bit n one cycle later.
- R5: In loopback, a `tx_valid` byte appears one cycle later on `rx_valid`/`rx_word`, zero-extended to 11 bits. Bytes on `line_rx_valid` are discarded.
- R6: In loopback, a write through `brk_we` that turns the break bit from 0 to 1 produces, one cycle later, a receive word with only bit 10 set. In that cycle this word takes precedence over any transmitted byte. A write that leaves the break bit on, or a break write while loopback is off, injects nothing.
- R7: With loopback off, control writes leave `ms_raw` unchanged. `stat_ms` follows `ext_ms` (same bit order as R2) within 3 cycles. Line bytes pass to `rx_word` one cycle later.
- R8: `pin_mc` ({OUT2,OUT1,RTS,DTR}, MSB first) follows the control register while loopback is off and is held at zero while loopback is on.
- R9: While loopback stays on, `stat_ms` ignores changes on `ext_ms`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_we | input | 1 | Control register write strobe |
| cr_lbe | input | 1 | Write data: loopback enable |
| cr_out2 | input | 1 | Write data: user output 2 |
| cr_out1 | input | 1 | Write data: user output 1 |
| cr_rts | input | 1 | Write data: request-to-send |
| cr_dtr | input | 1 | Write data: data-terminal-ready |
| brk_we | input | 1 | Send-break bit write strobe |
| brk_on | input | 1 | Write data: send-break bit |
| ms_clr | input | 4 | Raw modem interrupt clear, one bit per status |
| ext_ms | input | 4 | External modem status pins, asynchronous |
| tx_valid | input | 1 | Transmit character strobe |
| tx_data | input | 8 | Transmit character |
| line_rx_valid | input | 1 | Character from external receive line |
| line_rx_data | input | 8 | External receive character |
| stat_ms | output | 4 | Modem status flag bits |
| ms_raw | output | 4 | Modem status raw interrupt bits |
| pin_mc | output | 4 | External modem output pins |
| lb_active | output | 1 | Loopback enable currently set |
| rx_valid | output | 1 | Receive buffer push strobe |
| rx_word | output | 11 | Receive buffer word, bit 10 flags a break |

## Verification
The hardest case is the raw interrupt rebuild. It only becomes visible when some raw bits are already set and the new looped pattern differs from them. The stimulus first sets all four bits, then clears part of them through `ms_clr`. It then rewrites the control register with a sparser pattern, once alone and once in the same cycle as a clear. A break must also be reached through an edge while loopback is already on. So the bench first raises the break bit with loopback off, enables loopback, and checks that nothing is injected. It then toggles the break bit off and on.

// File: rtl/mdm_loop_pkg.sv
package mdm_loop_pkg;
   localparam int MS_RI  = 0;
   localparam int MS_DCD = 1;
   localparam int MS_CTS = 2;
   localparam int MS_DSR = 3;
   localparam int MS_W   = 4;

   typedef struct packed {
      logic lbe;
      logic out2;
      logic out1;
      logic rts;
      logic dtr;
   } mctl_t;

   function automatic logic [MS_W-1:0] loop_map(input mctl_t c);
      logic [MS_W-1:0] m;
      m         = '0;
      m[MS_RI]  = c.out2;
      m[MS_DCD] = c.out1;
      m[MS_CTS] = c.rts;
      m[MS_DSR] = c.dtr;
      return m;
   endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_status.sv
module mdm_status
   import mdm_loop_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cr_we,
   input  mctl_t           wr,
   input  logic [MS_W-1:0] ms_clr,
   input  logic [MS_W-1:0] ext_ms,
   output mctl_t           ctl_q,
   output logic [MS_W-1:0] stat_ms,
   output logic [MS_W-1:0] ms_raw
);
   logic [MS_W-1:0] ext_s;
   logic            next_lbe;
   logic            rebuild;

   mdm_sync #(.W(MS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ext_ms),
      .q    (ext_s)
   );

   assign next_lbe = cr_we ? wr.lbe : ctl_q.lbe;
   assign rebuild  = cr_we && wr.lbe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         stat_ms <= '0;
         ms_raw  <= '0;
      end else begin
         if (cr_we) ctl_q <= wr;
         if (rebuild) begin
            stat_ms <= loop_map(wr);
            ms_raw  <= loop_map(wr);
         end else begin
            if (!next_lbe) stat_ms <= ext_s;
            ms_raw <= ms_raw & ~ms_clr;
         end
      end
   end

   AST_CROSS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_we && wr.lbe) |=> (stat_ms[MS_RI] == $past(wr.out2) && stat_ms[MS_DCD] == $past(wr.out1)
                             && stat_ms[MS_CTS] == $past(wr.rts) && stat_ms[MS_DSR] == $past(wr.dtr))); // R2
   AST_RAW_REBUILD: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_we && wr.lbe) |=> (ms_raw == stat_ms)); // R4
   AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.lbe && !cr_we) |=> $stable(stat_ms)); // R9
   AST_OFF_NO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!next_lbe) |=> ((ms_raw & ~$past(ms_raw)) == '0)); // R7
endmodule

// File: rtl/mdm_rx_mux.sv
module mdm_rx_mux #(
   parameter int DATA_W  = 8,
   parameter int WORD_W  = 11,
   parameter int BRK_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lbe_q,
   input  logic              brk_we,
   input  logic              brk_on,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              line_valid,
   input  logic [DATA_W-1:0] line_data,
   output logic              rx_valid,
   output logic [WORD_W-1:0] rx_word
);
   localparam logic [WORD_W-1:0] BRK_WORD = WORD_W'(1) << BRK_BIT;

   logic brk_q;
   logic brk_rise;

   assign brk_rise = brk_we && brk_on && !brk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         brk_q    <= 1'b0;
         rx_valid <= 1'b0;
         rx_word  <= '0;
      end else begin
         if (brk_we) brk_q <= brk_on;
         if (lbe_q) begin
            rx_valid <= brk_rise || tx_valid;
            rx_word  <= brk_rise ? BRK_WORD : WORD_W'(tx_data);
         end else begin
            rx_valid <= line_valid;
            rx_word  <= WORD_W'(line_data);
         end
      end
   end

   AST_LINE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (lbe_q && !tx_valid && !brk_rise) |=> !rx_valid); // R5
   AST_BRK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (lbe_q && brk_rise) |=> (rx_valid && rx_word == BRK_WORD)); // R6
   AST_LINE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!lbe_q && line_valid) |=> (rx_valid && rx_word[BRK_BIT] == 1'b0)); // R7
endmodule

// File: rtl/uart_mdm_loop.sv
module uart_mdm_loop
   import mdm_loop_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int BRK_BIT     = 10,
   parameter int WORD_W      = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cr_we,
   input  logic              cr_lbe,
   input  logic              cr_out2,
   input  logic              cr_out1,
   input  logic              cr_rts,
   input  logic              cr_dtr,
   input  logic              brk_we,
   input  logic              brk_on,
   input  logic [3:0]        ms_clr,
   input  logic [3:0]        ext_ms,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              line_rx_valid,
   input  logic [DATA_W-1:0] line_rx_data,
   output logic [3:0]        stat_ms,
   output logic [3:0]        ms_raw,
   output logic [3:0]        pin_mc,
   output logic              lb_active,
   output logic              rx_valid,
   output logic [WORD_W-1:0] rx_word
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BRK_BIT < DATA_W || BRK_BIT >= WORD_W) begin : g_bad_brk
      $error("BRK_BIT must sit above the data field and inside the word");
   end

   mctl_t wr;
   mctl_t ctl_q;

   assign wr = '{lbe: cr_lbe, out2: cr_out2, out1: cr_out1, rts: cr_rts, dtr: cr_dtr};

   mdm_status #(.SYNC_STAGES(SYNC_STAGES)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .cr_we  (cr_we),
      .wr     (wr),
      .ms_clr (ms_clr),
      .ext_ms (ext_ms),
      .ctl_q  (ctl_q),
      .stat_ms(stat_ms),
      .ms_raw (ms_raw)
   );

   mdm_rx_mux #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BRK_BIT(BRK_BIT)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .lbe_q     (ctl_q.lbe),
      .brk_we    (brk_we),
      .brk_on    (brk_on),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .line_valid(line_rx_valid),
      .line_data (line_rx_data),
      .rx_valid  (rx_valid),
      .rx_word   (rx_word)
   );

   assign lb_active = ctl_q.lbe;
   assign pin_mc    = ctl_q.lbe ? 4'b0000 : {ctl_q.out2, ctl_q.out1, ctl_q.rts, ctl_q.dtr};

   AST_PINS_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_we && cr_lbe) |=> (pin_mc == 4'b0000)); // R8
endmodule

// File: tb/tb_uart_mdm_loop.sv
module tb_uart_mdm_loop;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cr_we, cr_lbe, cr_out2, cr_out1, cr_rts, cr_dtr;
   logic        brk_we, brk_on;
   logic [3:0]  ms_clr, ext_ms;
   logic        tx_valid, line_rx_valid;
   logic [7:0]  tx_data, line_rx_data;
   logic [3:0]  stat_ms, ms_raw, pin_mc;
   logic        lb_active, rx_valid;
   logic [10:0] rx_word;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   uart_mdm_loop dut (
      .clk(clk), .rst_n(rst_n), .cr_we(cr_we), .cr_lbe(cr_lbe), .cr_out2(cr_out2),
      .cr_out1(cr_out1), .cr_rts(cr_rts), .cr_dtr(cr_dtr), .brk_we(brk_we), .brk_on(brk_on),
      .ms_clr(ms_clr), .ext_ms(ext_ms), .tx_valid(tx_valid), .tx_data(tx_data),
      .line_rx_valid(line_rx_valid), .line_rx_data(line_rx_data), .stat_ms(stat_ms),
      .ms_raw(ms_raw), .pin_mc(pin_mc), .lb_active(lb_active), .rx_valid(rx_valid),
      .rx_word(rx_word)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // drive a control write at a falling edge; results are visible at the next falling edge
   task automatic wr_cr(input logic lbe, input logic o2, input logic o1, input logic rts,
                        input logic dtr, input logic [3:0] clr);
      @(negedge clk);
      cr_we = 1'b1; cr_lbe = lbe; cr_out2 = o2; cr_out1 = o1; cr_rts = rts; cr_dtr = dtr;
      ms_clr = clr;
      @(negedge clk);
      cr_we = 1'b0; ms_clr = 4'h0;
   endtask

   task automatic wr_brk(input logic on, input logic tv, input logic [7:0] td);
      @(negedge clk);
      brk_we = 1'b1; brk_on = on; tx_valid = tv; tx_data = td;
      @(negedge clk);
      brk_we = 1'b0; tx_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 stat", 16'(stat_ms), 16'h0);
      check("R1 raw", 16'(ms_raw), 16'h0);
      check("R1 pins/lb/rx", 16'({pin_mc, lb_active, rx_valid}), 16'h0);
   endtask

   task automatic t_off_mode;
      ext_ms = 4'b1010;
      wr_cr(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0);
      check("R8 pins follow", 16'(pin_mc), 16'b1011);
      check("R7 no raw when off", 16'(ms_raw), 16'h0);
      repeat (3) @(negedge clk);
      check("R7 stat follows pins", 16'(stat_ms), 16'b1010);
      @(negedge clk);
      line_rx_valid = 1'b1; line_rx_data = 8'h5A;
      @(negedge clk);
      line_rx_valid = 1'b0;
      check("R7 line pass", 16'({rx_valid, rx_word}), 16'({1'b1, 11'h05A}));
      // break edge while off: nothing injected
      wr_brk(1'b1, 1'b0, 8'h00);
      check("R6 no break when off", 16'(rx_valid), 16'h0);
   endtask

   task automatic t_enable_only;
      // same fields as before, only enable set: out2=1,out1=0,rts=1,dtr=1
      wr_cr(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0);
      check("R3 enable-only map", 16'(stat_ms), 16'b1101);
      check("R8 pins quiet", 16'({lb_active, pin_mc}), 16'b1_0000);
      check("R4 raw from looped", 16'(ms_raw), 16'b1101);
   endtask

   task automatic t_map;
      wr_cr(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
      check("R2 out1->DCD", 16'(stat_ms), 16'b0010);
      wr_cr(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
      check("R2 rts->CTS", 16'(stat_ms), 16'b0100);
      check("R4 rebuild clears old", 16'(ms_raw), 16'b0100);
   endtask

   task automatic t_hold;
      ext_ms = 4'b0011;
      repeat (5) @(negedge clk);
      check("R9 ext ignored", 16'(stat_ms), 16'b0100);
   endtask

   task automatic t_raw;
      wr_cr(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0);
      check("R4 all set", 16'(ms_raw), 16'hF);
      @(negedge clk);
      ms_clr = 4'b0011;
      @(negedge clk);
      ms_clr = 4'h0;
      check("R4 partial clear", 16'(ms_raw), 16'b1100);
      wr_cr(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
      check("R4 rebuild sparse", 16'(ms_raw), 16'b0001);
      wr_cr(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF);
      check("R4 rebuild beats clear", 16'(ms_raw), 16'b1000);
   endtask

   task automatic t_data;
      @(negedge clk);
      tx_valid = 1'b1; tx_data = 8'hC3; line_rx_valid = 1'b1; line_rx_data = 8'h11;
      @(negedge clk);
      tx_valid = 1'b0;
      check("R5 tx looped", 16'({rx_valid, rx_word}), 16'({1'b1, 11'h0C3}));
      @(negedge clk);
      line_rx_valid = 1'b0;
      check("R5 line dropped", 16'(rx_valid), 16'h0);
   endtask

   task automatic t_break;
      // break already on from the off-mode test: rewriting on is not an edge
      wr_brk(1'b1, 1'b0, 8'h00);
      check("R6 no edge no inject", 16'(rx_valid), 16'h0);
      wr_brk(1'b0, 1'b0, 8'h00);
      check("R6 off no inject", 16'(rx_valid), 16'h0);
      wr_brk(1'b1, 1'b1, 8'h77);
      check("R6 break word wins", 16'({rx_valid, rx_word}), 16'({1'b1, 11'h400}));
   endtask

   task automatic t_disable;
      ext_ms = 4'b0110;
      wr_cr(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0);
      check("R8 pins back", 16'(pin_mc), 16'b0001);
      check("R7 raw kept", 16'(ms_raw), 16'b1000);
      @(negedge clk);
      check("R7 stat from pins", 16'(stat_ms), 16'b0110);
   endtask

   initial begin
      rst_n = 1'b0;
      cr_we = 0; cr_lbe = 0; cr_out2 = 0; cr_out1 = 0; cr_rts = 0; cr_dtr = 0;
      brk_we = 0; brk_on = 0; ms_clr = 0; ext_ms = 0;
      tx_valid = 0; tx_data = 0; line_rx_valid = 0; line_rx_data = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_off_mode();
      t_enable_only();
      t_map();
      t_hold();
      t_raw();
      t_data();
      t_break();
      t_disable();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #20000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule